// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative cache of page translations. Each slot maps one virtual page number to a physical page number and belongs either to one address-space identifier or to all of them. A lookup presents a page number together with the current address-space identifier. One clock later the block returns a hit flag, the physical page number and the slot's permission and fault attributes.

New translations are written into the slot named by a rotating replacement pointer. The pointer ignores whatever the slot already holds. A command port offers three kinds of invalidation: drop every slot, drop every slot that is not global, or drop the slots that match one page and address-space pair. Walking page tables and raising faults are left to the surrounding logic.

Top module: `tlbx_xlate_buf`

## Requirements
- R1: After reset every slot is empty, so every lookup misses, and the replacement pointer is at slot 0.
- R2: A slot hits only when it is valid, its stored page tag equals `lk_vpn`, and either its global flag is set or its stored identifier equals `lk_asid`. On a hit the block returns the slot's PPN, global flag, per-mode read and write enable masks, and fault-on-read and fault-on-write flags.
- R3: Lookup results are registered. `lk_done` and `lk_hit` reflect a request presented on the previous clock edge. `lk_hit` and every returned field are 0 when there was no request or the request missed.
- R4: An accepted insert writes the slot at the replacement pointer, overwriting any valid entry there. The pointer then advances by one and wraps from slot ENTRIES-1 back to 0.
- R5: The stored tag is the upper VPN_W bits of `ins_vaddr`; the low OFS_W page-offset bits are discarded. The slot becomes valid.
- R6: Command 1 (invalidate all) clears every slot and returns the replacement pointer to slot 0.
- R7: Command 2 (invalidate local) clears every slot whose global flag is 0. Global slots stay valid.
- R8: Command 3 (invalidate page) clears every valid slot whose tag equals `cmd_vpn` and whose global flag is set or whose identifier equals `cmd_asid`. Under this rule a global slot with that tag is removed as well.
- R9: When several slots hit, the one with the lowest index supplies the result.
- R10: Writes take effect at the clock edge, so a lookup in the same cycle sees the earlier contents. A nonzero command (0 means none) in the same cycle as `ins_valid` takes precedence: the insert is dropped and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_done | output | 1 | A lookup was presented on the previous edge |
| lk_hit | output | 1 | That lookup found a translation |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_global | output | 1 | Global flag of the hit slot |
| lk_rd_en | output | MODES | Per-mode read enable mask |
| lk_wr_en | output | MODES | Per-mode write enable mask |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_valid | input | 1 | Insert request |
| ins_vaddr | input | VPN_W+OFS_W | Virtual address of the new mapping |
| ins_ppn | input | PPN_W | Physical page number to store |
| ins_asid | input | ASID_W | Identifier to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | MODES | Read enable mask to store |
| ins_wr_en | input | MODES | Write enable mask to store |
| ins_fault_rd | input | 1 | Fault-on-read flag to store |
| ins_fault_wr | input | 1 | Fault-on-write flag to store |
| cmd | input | 2 | 0 none, 1 invalidate all, 2 invalidate local, 3 invalidate page |
| cmd_vpn | input | VPN_W | Page number for command 3 |
| cmd_asid | input | ASID_W | Identifier for command 3 |

## Verification
A corrupted valid bit shows up at the next lookup of that page. It appears either as a stale hit after an invalidation or as a miss right after an insert, one cycle after the request. A replacement pointer that is off by one slot or fails to reset cannot be seen directly. It becomes visible only when two slots hold the same key, because the lowest-index rule then shows which one was written first, or when a full wrap evicts the wrong page. The bench builds exactly those situations. A wrong priority pick returns the other slot's PPN on the same cycle as the hit.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [1:0] {
    TLBX_NOP       = 2'd0,
    TLBX_INV_ALL   = 2'd1,
    TLBX_INV_LOCAL = 2'd2,
    TLBX_INV_PAGE  = 2'd3
  } tlbx_cmd_e;
endpackage

// File: rtl/tlbx_match.sv
// Tag and address-space compare for one slot (shared by lookup and page kill)
module tlbx_match #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              ent_valid,
  input  logic [VPN_W-1:0]  ent_tag,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_global,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              hit
);
  logic tag_eq, space_ok;
  assign tag_eq   = (ent_tag == key_vpn);
  assign space_ok = ent_global || (ent_asid == key_asid);
  assign hit      = ent_valid && tag_eq && space_ok;
endmodule

// File: rtl/tlbx_prio.sv
// Lowest-index selection among matching slots
module tlbx_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  assign any = |req;
  assign gnt = req & (~req + N'(1));

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  // R9
  prio_pick_chk: assert property (@(posedge clk) disable iff (rst)
    any |-> (gnt == (N'(1) << idx)));
endmodule

// File: rtl/tlbx_victim.sv
// Rotating replacement pointer
module tlbx_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) ptr <= '0;
    else if (step)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr == '0));
endmodule

// File: rtl/tlbx_xlate_buf.sv
module tlbx_xlate_buf
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int OFS_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int MODES   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [ASID_W-1:0]      lk_asid,
  output logic                   lk_done,
  output logic                   lk_hit,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic                   lk_global,
  output logic [MODES-1:0]       lk_rd_en,
  output logic [MODES-1:0]       lk_wr_en,
  output logic                   lk_fault_rd,
  output logic                   lk_fault_wr,
  input  logic                   ins_valid,
  input  logic [VPN_W+OFS_W-1:0] ins_vaddr,
  input  logic [PPN_W-1:0]       ins_ppn,
  input  logic [ASID_W-1:0]      ins_asid,
  input  logic                   ins_global,
  input  logic [MODES-1:0]       ins_rd_en,
  input  logic [MODES-1:0]       ins_wr_en,
  input  logic                   ins_fault_rd,
  input  logic                   ins_fault_wr,
  input  logic [1:0]             cmd,
  input  logic [VPN_W-1:0]       cmd_vpn,
  input  logic [ASID_W-1:0]      cmd_asid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PAY_W = PPN_W + 2 * MODES + 2;

  tlbx_cmd_e op;
  assign op = tlbx_cmd_e'(cmd);

  logic [ENTRIES-1:0] vld_q, glob_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PAY_W-1:0]   pay_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_req, kill_req, lk_gnt;
  logic [IDX_W-1:0]   lk_idx, ptr;
  logic               lk_any, ins_go;
  logic [VPN_W-1:0]   ins_vpn;
  logic [PAY_W-1:0]   ins_pay;

  assign ins_go  = ins_valid && (op == TLBX_NOP);
  assign ins_vpn = ins_vaddr[VPN_W+OFS_W-1:OFS_W];
  assign ins_pay = {ins_ppn, ins_rd_en, ins_wr_en, ins_fault_rd, ins_fault_wr};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlbx_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk (
      .ent_valid(vld_q[g]), .ent_tag(tag_q[g]), .ent_asid(asid_q[g]),
      .ent_global(glob_q[g]), .key_vpn(lk_vpn), .key_asid(lk_asid),
      .hit(lk_req[g]));
    tlbx_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_kill (
      .ent_valid(vld_q[g]), .ent_tag(tag_q[g]), .ent_asid(asid_q[g]),
      .ent_global(glob_q[g]), .key_vpn(cmd_vpn), .key_asid(cmd_asid),
      .hit(kill_req[g]));
  end

  tlbx_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst(rst), .req(lk_req), .gnt(lk_gnt), .idx(lk_idx), .any(lk_any));

  tlbx_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .clear(op == TLBX_INV_ALL), .step(ins_go), .ptr(ptr));

  // Valid and global flags: reset, invalidation, insert
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      glob_q <= '0;
    end else begin
      unique case (op)
        TLBX_INV_ALL:   vld_q <= '0;
        TLBX_INV_LOCAL: vld_q <= vld_q & glob_q;
        TLBX_INV_PAGE:  vld_q <= vld_q & ~kill_req;
        default: if (ins_go) begin
          vld_q[ptr]  <= 1'b1;
          glob_q[ptr] <= ins_global;
        end
      endcase
    end
  end

  // Tag and payload storage, no reset, single write port
  always_ff @(posedge clk) begin
    if (ins_go) begin
      tag_q[ptr]  <= ins_vpn;
      asid_q[ptr] <= ins_asid;
      pay_q[ptr]  <= ins_pay;
    end
  end

  // Registered lookup result
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_global <= 1'b0;
      {lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr} <= '0;
    end else begin
      lk_done <= lk_valid;
      lk_hit  <= lk_valid && lk_any;
      if (lk_valid && lk_any) begin
        lk_global <= glob_q[lk_idx];
        {lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr} <= pay_q[lk_idx];
      end else begin
        lk_global <= 1'b0;
        {lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr} <= '0;
      end
    end
  end

  // R3
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_valid));
  // R6
  inv_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (op == TLBX_INV_ALL) |=> (vld_q == '0));
  // R7
  inv_local_chk: assert property (@(posedge clk) disable iff (rst)
    (op == TLBX_INV_LOCAL) |=> ((vld_q & ~glob_q) == '0));
  // R10
  cmd_blocks_ins_chk: assert property (@(posedge clk) disable iff (rst)
    ((op != TLBX_NOP) && ins_valid) |=> ($countones(vld_q) <= $countones($past(vld_q))));
endmodule

// File: tb/sim_tlbx_xlate_buf.sv
module sim_tlbx_xlate_buf;
  localparam int VPN_W = 20, OFS_W = 12, PPN_W = 20, ASID_W = 8, MODES = 4, ENTRIES = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic lk_done, lk_hit, lk_global, lk_fault_rd, lk_fault_wr;
  logic [PPN_W-1:0] lk_ppn;
  logic [MODES-1:0] lk_rd_en, lk_wr_en;
  logic ins_valid = 0;
  logic [VPN_W+OFS_W-1:0] ins_vaddr = '0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic [ASID_W-1:0] ins_asid = '0;
  logic ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
  logic [MODES-1:0] ins_rd_en = '0, ins_wr_en = '0;
  logic [1:0] cmd = 2'd0;
  logic [VPN_W-1:0] cmd_vpn = '0;
  logic [ASID_W-1:0] cmd_asid = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlbx_xlate_buf u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ins(input int vpn, input int ppn, input int asid, input bit glob);
    ins_valid = 1; ins_vaddr = {VPN_W'(vpn), 12'hABC}; ins_ppn = PPN_W'(ppn);
    ins_asid = ASID_W'(asid); ins_global = glob;
    ins_rd_en = 4'b0101; ins_wr_en = 4'b0010; ins_fault_rd = 1; ins_fault_wr = 0;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic inv(input int c, input int vpn, input int asid);
    cmd = 2'(c); cmd_vpn = VPN_W'(vpn); cmd_asid = ASID_W'(asid);
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic look(input int vpn, input int asid);
    lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic expect_look(input int vpn, input int asid, input bit hit, input int ppn, input string req);
    look(vpn, asid);
    chk(lk_hit == hit, req, lk_hit, hit);
    if (hit) chk(lk_ppn == PPN_W'(ppn), req, lk_ppn, ppn);
    else     chk(lk_ppn == '0, req, lk_ppn, 0);
  endtask

  task automatic t_reset();
    chk(lk_hit == 0 && lk_done == 0, "R1", lk_hit, 0);
    expect_look(0, 0, 0, 0, "R1");
    chk(lk_done == 1, "R3", lk_done, 1);
  endtask

  task automatic t_basic();
    ins(20'h12345, 20'hABCDE, 3, 0);
    look(20'h12345, 3);
    chk(lk_hit == 1, "R5", lk_hit, 1);
    chk(lk_ppn == 20'hABCDE, "R2", lk_ppn, 20'hABCDE);
    chk(lk_rd_en == 4'b0101 && lk_wr_en == 4'b0010, "R2", {lk_rd_en, lk_wr_en}, 8'h52);
    chk(lk_fault_rd == 1 && lk_fault_wr == 0 && lk_global == 0, "R2",
        {lk_fault_rd, lk_fault_wr, lk_global}, 3'b100);
    @(negedge clk);
    chk(lk_hit == 0 && lk_done == 0 && lk_ppn == 0, "R3", {lk_done, lk_hit}, 0);
    expect_look(20'h12345, 4, 0, 0, "R2");
    expect_look(20'h12346, 3, 0, 0, "R2");
    ins(20'h00777, 20'h00555, 9, 1);
    expect_look(20'h00777, 200, 1, 20'h00555, "R2");
  endtask

  task automatic t_wrap();
    inv(1, 0, 0);
    for (int k = 0; k < ENTRIES; k++) ins(20'h100 + k, 20'h1000 + k, 1, 0);
    ins(20'h200, 20'h2000, 1, 0);
    expect_look(20'h100, 1, 0, 0, "R4");
    expect_look(20'h101, 1, 1, 20'h1001, "R4");
    expect_look(20'h200, 1, 1, 20'h2000, "R4");
  endtask

  task automatic t_prio_and_ptr_reset();
    inv(1, 0, 0);
    expect_look(20'h101, 1, 0, 0, "R6");
    ins(20'h55, 20'hAAA, 7, 0);
    ins(20'h55, 20'hBBB, 7, 0);
    expect_look(20'h55, 7, 1, 20'hAAA, "R9");
    for (int k = 0; k < 13; k++) ins(20'h300 + k, 20'h3, 1, 0);
    inv(1, 0, 0);
    ins(20'h66, 20'h111, 2, 0);
    ins(20'h66, 20'h222, 2, 0);
    expect_look(20'h66, 2, 1, 20'h111, "R6");
  endtask

  task automatic t_local();
    inv(1, 0, 0);
    ins(20'h10, 20'h710, 3, 1);
    ins(20'h11, 20'h711, 3, 0);
    inv(2, 0, 0);
    expect_look(20'h10, 3, 1, 20'h710, "R7");
    expect_look(20'h11, 3, 0, 0, "R7");
  endtask

  task automatic t_page();
    inv(1, 0, 0);
    ins(20'h20, 20'hA1, 1, 0);
    ins(20'h20, 20'hB2, 2, 0);
    ins(20'h20, 20'hC5, 5, 1);
    ins(20'h21, 20'hD1, 1, 0);
    inv(3, 20'h20, 1);
    expect_look(20'h20, 1, 0, 0, "R8");
    expect_look(20'h20, 2, 1, 20'hB2, "R8");
    expect_look(20'h20, 5, 0, 0, "R8");
    expect_look(20'h21, 1, 1, 20'hD1, "R8");
  endtask

  task automatic t_same_cycle();
    inv(1, 0, 0);
    lk_valid = 1; lk_vpn = 20'h40; lk_asid = 1;
    ins_valid = 1; ins_vaddr = {20'h40, 12'h0}; ins_ppn = 20'h440; ins_asid = 1; ins_global = 0;
    @(negedge clk);
    lk_valid = 0; ins_valid = 0;
    chk(lk_hit == 0, "R10", lk_hit, 0);
    expect_look(20'h40, 1, 1, 20'h440, "R10");
    lk_valid = 1; lk_vpn = 20'h40; lk_asid = 1; cmd = 2'd1;
    @(negedge clk);
    lk_valid = 0; cmd = 2'd0;
    chk(lk_hit == 1 && lk_ppn == 20'h440, "R10", lk_ppn, 20'h440);
    expect_look(20'h40, 1, 0, 0, "R10");
    cmd = 2'd2; ins_valid = 1; ins_vaddr = {20'h30, 12'h0}; ins_ppn = 20'h330;
    @(negedge clk);
    cmd = 2'd0; ins_valid = 0;
    expect_look(20'h30, 1, 0, 0, "R10");
    ins(20'h77, 20'h177, 1, 0);
    ins(20'h77, 20'h277, 1, 0);
    expect_look(20'h77, 1, 1, 20'h177, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_wrap();
    t_prio_and_ptr_reset();
    t_local();
    t_page();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule